// File: doc/BRIEF.md
# I2C Controller Byte Engine

This block is the controller side of an I2C link. It turns a short command from the host into a complete bus transaction. On a start request it issues a START, then sends one address byte: the 7-bit target address, followed by a direction bit. It then moves a set number of data bytes, either out to the target or in from it, and ends with a STOP. The SCL rate is the reference clock divided by a power of two. A 3-bit select register chooses the divider.

After every byte it sends, the engine samples the target's acknowledge. A missing acknowledge raises a sticky no-acknowledge flag, releases the bus through a STOP and drops any pending repeated-START request. When the host sets the repeated-START request during a transfer, the engine waits for the current acknowledge slot to end. It then issues a new START, sends the address byte again and restarts the byte count. In receive direction the engine acknowledges every byte except the last. It answers the last byte with a no-acknowledge before the STOP.

Top module: `i2c_ctl_engine`

## Requirements
- R1: After reset, `scl_o` and `sda_o` are 1 (released), `busy`, `nack_flag` and `rs_pending` are 0, and the divider select holds code 001.
- R2: One SCL period lasts 32·2^s reference clocks, where s is the divider select code (000 gives /32, 111 gives /4096). Each period is split into four equal quarters.
- R3: The first byte after every START is `{tgt_addr[6:0], dir}`, sent MSB first, with `dir` in bit 0. `dir`=0 means the controller transmits and `dir`=1 means it receives.
- R4: When `dir`=0, the engine sends `xfer_len` data bytes MSB first. It samples `tx_data` at the cycle in which `tx_take` pulses. It then issues exactly one STOP.
- R5: When `dir`=1, the engine receives `xfer_len` bytes. Each byte is presented on `rx_data` with a one-cycle `rx_valid` pulse. The engine drives ACK (SDA low) after every byte but the last and NACK (SDA high) after the last.
- R6: If the address byte is not acknowledged, `nack_flag` sets, the engine issues STOP and no data byte is sent.
- R7: If a transmitted data byte is not acknowledged, `nack_flag` sets and the engine issues STOP without sending further bytes.
- R8: A `rs_set` pulse sets `rs_pending`. At the end of the next acknowledged byte, the engine issues a repeated START, resends the address byte and clears `rs_pending`.
- R9: A NACK clears `rs_pending`, and no repeated START follows.
- R10: `busy` is 1 from the cycle after an accepted `start_req` until the STOP completes. While `busy` is 0, SCL and SDA are both released.
- R11: A `nack_clr` pulse clears `nack_flag`. A new NACK takes priority over a clear in the same cycle.
- R12: SDA changes while SCL is high only as part of a START or STOP condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; gates acceptance of `start_req` |
| div_we | input | 1 | Write strobe for the divider select |
| div_wdata | input | 3 | New divider select code |
| start_req | input | 1 | Begin a transaction (taken while idle) |
| tgt_addr | input | 7 | Target address |
| dir | input | 1 | 0 controller transmit, 1 controller receive |
| xfer_len | input | LEN_W | Number of data bytes |
| tx_data | input | 8 | Next byte to transmit |
| tx_take | output | 1 | Pulse: `tx_data` was loaded |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulse: `rx_data` is new |
| rs_set | input | 1 | Request a repeated START |
| rs_pending | output | 1 | Repeated START still pending |
| nack_clr | input | 1 | Clear the no-acknowledge flag |
| nack_flag | output | 1 | Sticky no-acknowledge interrupt flag |
| busy | output | 1 | Transaction in progress |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level (1 = released) |
| sda_i | input | 1 | Sampled SDA bus level |

## Verification
The bench builds the engine with its default parameters: a 4-bit length field, a quarter-phase base of 8 clocks and reset select 001. Under this setting the full divider range fits in the cycle budget. It runs an address-only transaction at every one of the eight select codes and measures the SCL period against 32·2^s. All other transactions run at the fastest divider, so short write and read lengths fit within the budget. These transactions cover NACK on the address byte and on each data position, a repeated START alone and a repeated START combined with a NACK, all checked against a bus-level target model.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
    localparam int DIV_SEL_W = 3;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BIT   = 2'd2,
        ST_STOP  = 2'd3
    } ctl_st_e;
endpackage

// File: rtl/i2c_ctl_prescale.sv
module i2c_ctl_prescale
    import i2c_ctl_pkg::*;
#(
    parameter int QLOG_BASE = 3,
    parameter logic [DIV_SEL_W-1:0] DIV_RST = 3'b001
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 div_we,
    input  logic [DIV_SEL_W-1:0] div_wdata,
    output logic                 qtick
);
    localparam int CNT_W = QLOG_BASE + (1 << DIV_SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [DIV_SEL_W-1:0] sel;
    } pre_s;

    pre_s q, d;
    logic [CNT_W-1:0] lim;

    // quarter-phase length is 2^(QLOG_BASE+sel) clocks
    always_comb begin
        lim = CNT_W'((32'd1 << (QLOG_BASE + 32'(q.sel))) - 32'd1);
    end

    assign qtick = run && (q.cnt >= lim);

    always_comb begin
        d = q;
        if (div_we) d.sel = div_wdata;
        if (!run || qtick) d.cnt = '0;
        else               d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.sel <= DIV_RST;
        end else begin
            q <= d;
        end
    end

    // R2: a quarter boundary restarts the count
    a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $past(qtick)) |-> (q.cnt == '0));

    // R2: counter idles at zero outside a transaction
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (q.cnt == '0));
endmodule

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq
    import i2c_ctl_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_req,
    input  logic              qtick,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              dir,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              rs_set,
    input  logic              nack_clr,
    input  logic              sda_i,
    output logic              tx_take,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rs_pending,
    output logic              nack_flag,
    output logic              busy,
    output logic              scl_o,
    output logic              sda_o
);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

    typedef struct packed {
        ctl_st_e           st;
        logic [1:0]        ph;
        logic [3:0]        bitn;
        logic [BYTE_W-1:0] sh;
        logic              ackb;
        logic              addr_ph;
        logic              dir;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic              rs;
        logic              nack;
        logic              scl;
        logic              sda;
        logic              tx_take;
        logic              rx_valid;
        logic [BYTE_W-1:0] rx_data;
    } seq_s;

    seq_s q, d;

    logic             txmode;
    logic             last_rx;
    logic [LEN_W-1:0] cnt_nx;
    logic [3:0]       bit_nx;

    always_comb begin
        txmode  = q.addr_ph || !q.dir;
        last_rx = (LEN_W'(q.cnt + 1'b1) == q.len);
        cnt_nx  = q.addr_ph ? '0 : LEN_W'(q.cnt + 1'b1);
        bit_nx  = q.bitn + 4'd1;
    end

    always_comb begin
        d          = q;
        d.tx_take  = 1'b0;
        d.rx_valid = 1'b0;
        if (nack_clr) d.nack = 1'b0;
        if (rs_set)   d.rs   = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (en && start_req) begin
                    d.st  = ST_START;
                    d.ph  = 2'd0;
                    d.len = xfer_len;
                    d.cnt = '0;
                    d.scl = 1'b1;
                    d.sda = 1'b1;
                end
            end

            ST_START: begin
                if (qtick) begin
                    d.ph = q.ph + 2'd1;
                    unique case (q.ph)
                        2'd0: begin d.scl = 1'b1; d.sda = 1'b1; end
                        2'd1: begin d.scl = 1'b1; d.sda = 1'b0; end
                        2'd2: begin d.scl = 1'b0; d.sda = 1'b0; end
                        default: begin
                            d.st      = ST_BIT;
                            d.ph      = 2'd0;
                            d.bitn    = 4'd0;
                            d.addr_ph = 1'b1;
                            d.dir     = dir;
                            d.cnt     = '0;
                            d.sh      = {tgt_addr, dir};
                            d.scl     = 1'b0;
                            d.sda     = tgt_addr[ADDR_W-1];
                        end
                    endcase
                end
            end

            ST_BIT: begin
                if (qtick) begin
                    d.ph = q.ph + 2'd1;
                    unique case (q.ph)
                        2'd0: d.scl = 1'b1;
                        2'd1: begin
                            if (q.bitn != ACK_SLOT) d.sh = {q.sh[BYTE_W-2:0], sda_i};
                            else                    d.ackb = sda_i;
                        end
                        2'd2: d.scl = 1'b0;
                        default: begin
                            d.ph = 2'd0;
                            if (q.bitn != ACK_SLOT) begin
                                d.bitn = bit_nx;
                                if (bit_nx == ACK_SLOT)
                                    d.sda = txmode ? 1'b1 : last_rx;
                                else
                                    d.sda = txmode ? q.sh[BYTE_W-1] : 1'b1;
                            end else begin
                                d.rx_valid = !q.addr_ph && q.dir;
                                d.rx_data  = q.sh;
                                if (txmode && q.ackb) begin
                                    d.nack = 1'b1;
                                    d.rs   = 1'b0;
                                    d.st   = ST_STOP;
                                    d.sda  = 1'b0;
                                end else if (q.rs) begin
                                    d.rs  = 1'b0;
                                    d.st  = ST_START;
                                    d.sda = 1'b1;
                                end else begin
                                    d.cnt = cnt_nx;
                                    if (cnt_nx == q.len) begin
                                        d.st  = ST_STOP;
                                        d.sda = 1'b0;
                                    end else begin
                                        d.addr_ph = 1'b0;
                                        d.bitn    = 4'd0;
                                        if (!q.dir) begin
                                            d.sh      = tx_data;
                                            d.tx_take = 1'b1;
                                            d.sda     = tx_data[BYTE_W-1];
                                        end else begin
                                            d.sh  = '0;
                                            d.sda = 1'b1;
                                        end
                                    end
                                end
                            end
                        end
                    endcase
                end
            end

            default: begin // ST_STOP
                if (qtick) begin
                    d.ph = q.ph + 2'd1;
                    unique case (q.ph)
                        2'd0: begin d.scl = 1'b1; d.sda = 1'b0; end
                        2'd1: begin d.scl = 1'b1; d.sda = 1'b1; end
                        2'd2: ;
                        default: begin
                            d.st = ST_IDLE;
                            d.ph = 2'd0;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.scl <= 1'b1;
            q.sda <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_take    = q.tx_take;
    assign rx_data    = q.rx_data;
    assign rx_valid   = q.rx_valid;
    assign rs_pending = q.rs;
    assign nack_flag  = q.nack;
    assign busy       = (q.st != ST_IDLE);
    assign scl_o      = q.scl;
    assign sda_o      = q.sda;

    // R12: SDA moves under a high SCL only inside START or STOP
    a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.scl) && q.scl && (q.sda != $past(q.sda)))
            |-> (q.st == ST_START || q.st == ST_STOP));

    // R10: both lines released whenever the engine is idle
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o));

    // R6 / R7: a new NACK always heads for STOP
    a_r6_nack_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.nack) |-> (q.st == ST_STOP));

    // R9: a NACK drops the repeated-START request
    a_r9_nack_drops_rs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.nack) |-> !q.rs);

    // R8: the request is consumed only by a restart or a NACK stop
    a_r8_rs_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rs) |-> (q.st == ST_START || q.st == ST_STOP));

    // R4: data is loaded only at the start of a bit
    a_r4_take_at_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> (q.st == ST_BIT && q.bitn == 4'd0 && !q.scl));
endmodule

// File: rtl/i2c_ctl_engine.sv
module i2c_ctl_engine
    import i2c_ctl_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int QLOG_BASE = 3,
    parameter logic [DIV_SEL_W-1:0] DIV_RST = 3'b001
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 div_we,
    input  logic [DIV_SEL_W-1:0] div_wdata,
    input  logic                 start_req,
    input  logic [ADDR_W-1:0]    tgt_addr,
    input  logic                 dir,
    input  logic [LEN_W-1:0]     xfer_len,
    input  logic [BYTE_W-1:0]    tx_data,
    output logic                 tx_take,
    output logic [BYTE_W-1:0]    rx_data,
    output logic                 rx_valid,
    input  logic                 rs_set,
    output logic                 rs_pending,
    input  logic                 nack_clr,
    output logic                 nack_flag,
    output logic                 busy,
    output logic                 scl_o,
    output logic                 sda_o,
    input  logic                 sda_i
);
    logic qtick;

    i2c_ctl_prescale #(
        .QLOG_BASE (QLOG_BASE),
        .DIV_RST   (DIV_RST)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div_we    (div_we),
        .div_wdata (div_wdata),
        .qtick     (qtick)
    );

    i2c_ctl_seq #(
        .LEN_W (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .start_req  (start_req),
        .qtick      (qtick),
        .tgt_addr   (tgt_addr),
        .dir        (dir),
        .xfer_len   (xfer_len),
        .tx_data    (tx_data),
        .rs_set     (rs_set),
        .nack_clr   (nack_clr),
        .sda_i      (sda_i),
        .tx_take    (tx_take),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rs_pending (rs_pending),
        .nack_flag  (nack_flag),
        .busy       (busy),
        .scl_o      (scl_o),
        .sda_o      (sda_o)
    );
endmodule

// File: tb/sim_i2c_ctl_engine.sv
`timescale 1ns/1ps
module sim_i2c_ctl_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       div_we = 1'b0;
    logic [2:0] div_wdata = 3'd0;
    logic       start_req = 1'b0;
    logic [6:0] tgt_addr = 7'd0;
    logic       dir = 1'b0;
    logic [3:0] xfer_len = 4'd0;
    logic [7:0] tx_data;
    logic       tx_take;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rs_set = 1'b0;
    logic       rs_pending;
    logic       nack_clr = 1'b0;
    logic       nack_flag;
    logic       busy;
    logic       scl_o, sda_o, sda_i;

    logic tgt_sda = 1'b1;
    assign sda_i = sda_o & tgt_sda;

    always #2 clk = ~clk;

    i2c_ctl_engine u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .div_we(div_we), .div_wdata(div_wdata),
        .start_req(start_req), .tgt_addr(tgt_addr), .dir(dir), .xfer_len(xfer_len),
        .tx_data(tx_data), .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid),
        .rs_set(rs_set), .rs_pending(rs_pending), .nack_clr(nack_clr),
        .nack_flag(nack_flag), .busy(busy), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    function automatic logic [7:0] wrpat(input int k);
        return 8'(8'h5C + k * 8'h27);
    endfunction
    function automatic logic [7:0] rdpat(input int k);
        return 8'(8'hA5 ^ (k * 8'h3B));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bus-level target model
    logic mclr = 1'b0;
    int   nack_at = -1;
    int   nstart, nstop, naddr, nw, rxn, txk, bitn, byte_i, rise0, rise1;
    logic in_ack, rd, rd_done, pscl, psda;
    logic [7:0] sh, tmp;
    logic [7:0] addrlog [4];
    logic [7:0] wlog [16];
    logic [7:0] rxlog [16];
    logic       mack [16];

    assign tx_data = wrpat(txk);

    always @(negedge clk) begin
        cyc++;
        if (mclr || !rst_n) begin
            nstart = 0; nstop = 0; naddr = 0; nw = 0; rxn = 0; txk = 0;
            bitn = 0; byte_i = 0; in_ack = 1'b0; rd = 1'b0; rd_done = 1'b0;
            rise0 = 0; rise1 = 0; tgt_sda = 1'b1; pscl = 1'b1; psda = 1'b1;
            for (int i = 0; i < 16; i++) mack[i] = 1'b0;
        end else begin
            if (tx_take) txk++;
            if (rx_valid) begin rxlog[rxn % 16] = rx_data; rxn++; end
            if (pscl && scl_o && psda && !sda_i) begin
                nstart++; bitn = 0; byte_i = 0; in_ack = 1'b0;
                rd_done = 1'b0; tgt_sda = 1'b1;
            end else if (pscl && scl_o && !psda && sda_i) begin
                nstop++;
            end else if (!pscl && scl_o) begin
                if (!in_ack && bitn < 8) begin
                    if (naddr == 0 && byte_i == 0 && bitn == 0) rise0 = cyc;
                    if (naddr == 0 && byte_i == 0 && bitn == 1) rise1 = cyc;
                    sh = {sh[6:0], sda_i};
                    bitn++;
                end else if (in_ack && byte_i > 0 && rd) begin
                    mack[byte_i % 16] = sda_i;
                end
            end else if (pscl && !scl_o) begin
                if (in_ack) begin
                    in_ack = 1'b0; tgt_sda = 1'b1;
                    if (byte_i > 0 && rd && mack[byte_i % 16]) rd_done = 1'b1;
                    byte_i++; bitn = 0;
                end else if (bitn == 8) begin
                    in_ack = 1'b1;
                    if (byte_i == 0) begin
                        addrlog[naddr % 4] = sh; naddr++; rd = sh[0];
                    end else if (!rd) begin
                        wlog[nw % 16] = sh; nw++;
                    end
                    if (byte_i == 0 || !rd) tgt_sda = (byte_i == nack_at);
                    else                    tgt_sda = 1'b1;
                end
                if (!in_ack && rd && byte_i > 0 && bitn < 8 && !rd_done) begin
                    tmp = rdpat(byte_i);
                    tgt_sda = tmp[7 - bitn];
                end
            end
            pscl = scl_o; psda = sda_i;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic set_div(input logic [2:0] s);
        div_wdata = s; div_we = 1'b1; tick(); div_we = 1'b0;
    endtask

    task automatic xfer(input logic [6:0] a, input logic d, input int len,
                        input int nk, input logic rs);
        nack_at = nk;
        mclr = 1'b1; tick(); tick(); mclr = 1'b0;
        tgt_addr = a; dir = d; xfer_len = 4'(len);
        start_req = 1'b1; tick(); start_req = 1'b0;
        @(negedge clk);
        chk("R10 busy after start", int'(busy), 1);
        if (rs) begin tick(); rs_set = 1'b1; tick(); rs_set = 1'b0; end
        while (busy && cyc < 190000) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl", int'(scl_o), 1);
        chk("R1 sda", int'(sda_o), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 nack", int'(nack_flag), 0);
        chk("R1 rs", int'(rs_pending), 0);

        // R1/R2 default divider /64
        xfer(7'h2A, 1'b0, 0, -1, 1'b0);
        chk("R1 R2 default period", rise1 - rise0, 64);

        // R2/R3 sweep all eight divider codes
        for (int s = 0; s < 8; s++) begin
            set_div(3'(s));
            xfer(7'(7'h11 + s * 13), 1'b0, 0, -1, 1'b0);
            chk("R2 scl period", rise1 - rise0, 32 << s);
            chk("R3 address byte", int'(addrlog[0]), int'({7'(7'h11 + s * 13), 1'b0}));
            chk("R10 one stop", nstop, 1);
            chk("R10 idle lines", int'(scl_o & sda_o), 1);
        end
        set_div(3'd0);

        // R4 writes of several lengths
        for (int len = 1; len <= 4; len++) begin
            xfer(7'(7'h40 + len), 1'b0, len, -1, 1'b0);
            chk("R4 bytes seen", nw, len);
            chk("R4 takes", txk, len);
            for (int i = 0; i < len; i++)
                chk("R4 data", int'(wlog[i]), int'(wrpat(i)));
            chk("R4 stops", nstop, 1);
            chk("R4 starts", nstart, 1);
            chk("R7 no nack", int'(nack_flag), 0);
        end

        // R5 reads, R3 direction bit
        for (int len = 1; len <= 3; len++) begin
            xfer(7'h33, 1'b1, len, -1, 1'b0);
            chk("R3 read addr", int'(addrlog[0]), int'({7'h33, 1'b1}));
            chk("R5 rx count", rxn, len);
            for (int i = 0; i < len; i++) begin
                chk("R5 rx data", int'(rxlog[i]), int'(rdpat(i + 1)));
                chk("R5 ctl ack", int'(mack[i + 1]), (i + 1 == len) ? 1 : 0);
            end
            chk("R5 stops", nstop, 1);
            chk("R5 no nack", int'(nack_flag), 0);
        end

        // R6 address NACK
        xfer(7'h50, 1'b0, 3, 0, 1'b0);
        chk("R6 nack flag", int'(nack_flag), 1);
        chk("R6 no data", nw, 0);
        chk("R6 no take", txk, 0);
        chk("R6 stop", nstop, 1);
        chk("R6 idle", int'(busy), 0);

        // R11 clear
        nack_clr = 1'b1; tick(); nack_clr = 1'b0;
        @(negedge clk);
        chk("R11 cleared", int'(nack_flag), 0);

        // R7 NACK on each data position
        for (int k = 1; k <= 3; k++) begin
            xfer(7'h21, 1'b0, 4, k, 1'b0);
            chk("R7 nack flag", int'(nack_flag), 1);
            chk("R7 bytes sent", nw, k);
            chk("R7 stop", nstop, 1);
            nack_clr = 1'b1; tick(); nack_clr = 1'b0;
        end

        // R8 repeated START
        xfer(7'h6E, 1'b0, 2, -1, 1'b1);
        chk("R8 starts", nstart, 2);
        chk("R8 addr count", naddr, 2);
        chk("R8 second addr", int'(addrlog[1]), int'({7'h6E, 1'b0}));
        chk("R8 data after restart", nw, 2);
        chk("R8 data0", int'(wlog[0]), int'(wrpat(0)));
        chk("R8 rs cleared", int'(rs_pending), 0);
        chk("R8 stop", nstop, 1);

        // R9 NACK cancels repeated START
        xfer(7'h0F, 1'b0, 2, 0, 1'b1);
        chk("R9 starts", nstart, 1);
        chk("R9 rs cleared", int'(rs_pending), 0);
        chk("R9 nack", int'(nack_flag), 1);
        chk("R12 stop", nstop, 1);

        if (cyc >= 190000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 195000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule